// File: doc/BRIEF.md
# Dual-Channel Power-Good Reset Delay Generator

This block watches two regulated supply rails through digital comparator flags and drives one active-low reset request per rail. Each channel reports a rail as good only after the rail has stayed above its upper threshold for a long, uninterrupted time. It drops the good state only after the rail has stayed below its lower threshold for a short, uninterrupted time. The gap between the two thresholds gives hysteresis. The gap between the two times gives asymmetric qualification. Each output is an open-drain style pull-low enable: `1` means the pin is pulled low (reset held), and `0` means the pin is released.

Channel 0 has fixed entry and exit times. Channel 1 scales both times linearly with a setting value that stands in for an external timing capacitor. That setting saturates at a lower clamp, so the exit time can never fall below a glitch-immunity floor. All times are counted in clock ticks derived from a clock-rate parameter given in kHz.

Each channel is a three-state machine with these states:
- `PG_OFF`: the rail is disabled or locked out.
- `PG_ARM`: the channel is qualifying entry.
- `PG_GOOD`: power is good, and the channel is qualifying exit.

Transitions:
- off-to-arm: the channel becomes active.
- arm-to-good: the entry run completes.
- good-to-arm: the exit run completes.
- any-to-off: the channel is disabled or undervoltage lockout is asserted.

Top module: `pg_reset_pair`

## Requirements
- R1: After reset, both pull-low outputs are 1, and they stay 1 until an entry time has been qualified.
- R2: On an armed, not-good channel, the pull-low output goes to 0 right after the ENTRY-th consecutive clock edge at which the above-threshold flag is 1. ENTRY is 100 ticks for channel 0 in the bench build.
- R3: A single edge with the above-threshold flag at 0 restarts the entry count from zero.
- R4: On a good channel, the pull-low output returns to 1 right after the EXIT-th consecutive edge with the below-threshold flag at 1. A single edge without the flag restarts the exit count.
- R5: While neither flag is set, a channel keeps its current good or not-good state indefinitely.
- R6: When the enable is 0 or the shared lockout input is 1 at an edge, the pull-low output is 1 after that edge and both counts are cleared. Re-entry then needs the full arming and entry time.
- R7: For channel 1, entry = S × ENTRY_STEP ticks and exit = S × EXIT_STEP ticks, where S is the setting. A new setting governs the counts from the second edge after it is applied.
- R8: A setting below MIN_SET, the smallest value whose exit time reaches the 10 µs floor, behaves exactly as MIN_SET. The setting values 0 and 1 therefore give an exit of 10 ticks and an entry of 100 ticks in the bench build.
- R9: The two channels are independent: disabling one never changes the other's output.
- R10: The first edge after a channel becomes active only arms it. The flags are not counted at that edge, so a fresh start releases after ENTRY+1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo | input | 1 | Shared undervoltage lockout; 1 forces both channels off |
| reg0_en | input | 1 | Rail 0 regulator enable |
| reg0_above | input | 1 | Rail 0 is above the upper (entry) threshold |
| reg0_below | input | 1 | Rail 0 is below the lower (exit) threshold |
| reg1_en | input | 1 | Rail 1 regulator enable |
| reg1_above | input | 1 | Rail 1 is above the upper (entry) threshold |
| reg1_below | input | 1 | Rail 1 is below the lower (exit) threshold |
| reg1_delay_set | input | SET_W | Rail 1 delay scale setting |
| reg0_pull_low | output | 1 | 1 = drive rail 0 reset pin low |
| reg1_pull_low | output | 1 | 1 = drive rail 1 reset pin low |

## Verification
The bench builds the block with a 1000 kHz tick rate, so each microsecond is one tick. It shortens channel 0's entry to 100 µs and channel 1's nominal entry to 250 µs at setting 5, keeping 25 µs exits and the 10 µs floor. With these values the exact release and drop edges for fixed, scaled and clamped settings can be reached in a few hundred cycles. The 10-tick floor makes the clamp visible at setting 0 and 1, where the step of 5 ticks would otherwise give 0 or 5.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [1:0] {
        PG_OFF  = 2'd0,
        PG_ARM  = 2'd1,
        PG_GOOD = 2'd2
    } pg_state_e;

    function automatic longint pg_ticks(input longint khz, input longint usec);
        return (khz * usec) / 1000;
    endfunction

    function automatic longint pg_max(input longint a, input longint b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pg_delay_cfg.sv
module pg_delay_cfg
    import pg_pkg::*;
#(
    parameter int     SET_W     = 8,
    parameter int     CNT_W     = 28,
    parameter longint ENT_STEP  = 1000000,
    parameter longint EX_STEP   = 125,
    parameter longint MIN_SET   = 10,
    parameter longint MIN_EXIT  = 1250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] setting,
    output logic [CNT_W-1:0] ent_len,
    output logic [CNT_W-1:0] ex_len
);
    localparam logic [CNT_W-1:0] ENT_STEP_W = CNT_W'(ENT_STEP);
    localparam logic [CNT_W-1:0] EX_STEP_W  = CNT_W'(EX_STEP);
    localparam logic [SET_W-1:0] MIN_SET_W  = SET_W'(MIN_SET);

    logic [SET_W-1:0] set_sat;

    always_comb begin
        set_sat = (setting < MIN_SET_W) ? MIN_SET_W : setting;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_len <= CNT_W'(MIN_SET_W) * ENT_STEP_W;
            ex_len  <= CNT_W'(MIN_SET_W) * EX_STEP_W;
        end else begin
            ent_len <= CNT_W'(set_sat) * ENT_STEP_W;
            ex_len  <= CNT_W'(set_sat) * EX_STEP_W;
        end
    end

    AST_EXIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ex_len >= CNT_W'(MIN_EXIT)); // R8

    AST_ENTRY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ent_len != '0); // R7

endmodule

// File: rtl/pg_channel.sv
module pg_channel
    import pg_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             above,
    input  logic             below,
    input  logic [CNT_W-1:0] ent_len,
    input  logic [CNT_W-1:0] ex_len,
    output logic             pull_low
);
    pg_state_e        state_q, state_d;
    logic [CNT_W-1:0] run_q, run_d;
    logic [CNT_W-1:0] limit;
    logic             done;
    logic             good;

    always_comb begin
        limit   = (state_q == PG_GOOD) ? ex_len : ent_len;
        done    = (run_q + CNT_W'(1)) >= limit;
        state_d = state_q;
        run_d   = run_q;
        if (!active) begin
            state_d = PG_OFF;
            run_d   = '0;
        end else begin
            unique case (state_q)
                PG_OFF: begin
                    state_d = PG_ARM;
                    run_d   = '0;
                end
                PG_ARM: begin
                    if (!above) begin
                        run_d = '0;
                    end else if (done) begin
                        state_d = PG_GOOD;
                        run_d   = '0;
                    end else begin
                        run_d = run_q + CNT_W'(1);
                    end
                end
                PG_GOOD: begin
                    if (!below) begin
                        run_d = '0;
                    end else if (done) begin
                        state_d = PG_ARM;
                        run_d   = '0;
                    end else begin
                        run_d = run_q + CNT_W'(1);
                    end
                end
                default: begin
                    state_d = PG_OFF;
                    run_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_OFF;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        good     = (state_q == PG_GOOD);
        pull_low = !good;
    end

    AST_OFF_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> pull_low); // R6

    AST_ENTRY_NEEDS_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_low) |-> $past(above)); // R2

    AST_EXIT_NEEDS_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pull_low) && $past(active)) |-> $past(below)); // R4

    AST_BAND_HOLDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pull_low && active && !below) |=> !pull_low); // R5

    AST_ARM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_OFF) |=> pull_low); // R10

endmodule

// File: rtl/pg_reset_pair.sv
module pg_reset_pair
    import pg_pkg::*;
#(
    parameter longint CLK_KHZ          = 125000,
    parameter longint CH0_ENTRY_US     = 2000,
    parameter longint CH0_EXIT_US      = 25,
    parameter longint CH1_ENTRY_NOM_US = 200000,
    parameter longint CH1_EXIT_NOM_US  = 25,
    parameter longint CH1_NOM_SET      = 25,
    parameter longint MIN_EXIT_US      = 10,
    parameter int     SET_W            = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo,
    input  logic             reg0_en,
    input  logic             reg0_above,
    input  logic             reg0_below,
    input  logic             reg1_en,
    input  logic             reg1_above,
    input  logic             reg1_below,
    input  logic [SET_W-1:0] reg1_delay_set,
    output logic             reg0_pull_low,
    output logic             reg1_pull_low
);
    localparam int     NCH       = 2;
    localparam longint ENT0      = pg_ticks(CLK_KHZ, CH0_ENTRY_US);
    localparam longint EXIT0     = pg_ticks(CLK_KHZ, CH0_EXIT_US);
    localparam longint MIN_EXIT  = pg_ticks(CLK_KHZ, MIN_EXIT_US);
    localparam longint ENT_STEP  = pg_ticks(CLK_KHZ, CH1_ENTRY_NOM_US) / CH1_NOM_SET;
    localparam longint EX_STEP   = pg_ticks(CLK_KHZ, CH1_EXIT_NOM_US) / CH1_NOM_SET;
    localparam longint MIN_SET   = pg_max(1, (MIN_EXIT + EX_STEP - 1) / EX_STEP);
    localparam longint SET_MAX   = (longint'(1) << SET_W) - 1;
    localparam longint LEN_MAX   = pg_max(pg_max(ENT0, EXIT0), SET_MAX * ENT_STEP);
    localparam int     CNT_W     = $clog2(LEN_MAX + 1);

    logic [NCH-1:0]   ch_en, ch_above, ch_below, ch_active, ch_pull;
    logic [CNT_W-1:0] ent_len [NCH];
    logic [CNT_W-1:0] ex_len  [NCH];

    assign ch_en    = {reg1_en, reg0_en};
    assign ch_above = {reg1_above, reg0_above};
    assign ch_below = {reg1_below, reg0_below};

    assign ent_len[0] = CNT_W'(ENT0);
    assign ex_len[0]  = CNT_W'(EXIT0);

    pg_delay_cfg #(
        .SET_W    (SET_W),
        .CNT_W    (CNT_W),
        .ENT_STEP (ENT_STEP),
        .EX_STEP  (EX_STEP),
        .MIN_SET  (MIN_SET),
        .MIN_EXIT (MIN_EXIT)
    ) u_cfg1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .setting (reg1_delay_set),
        .ent_len (ent_len[1]),
        .ex_len  (ex_len[1])
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_active[g] = ch_en[g] && !uvlo;

        pg_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (ch_active[g]),
            .above    (ch_above[g]),
            .below    (ch_below[g]),
            .ent_len  (ent_len[g]),
            .ex_len   (ex_len[g]),
            .pull_low (ch_pull[g])
        );
    end

    assign reg0_pull_low = ch_pull[0];
    assign reg1_pull_low = ch_pull[1];

    AST_LOCKOUT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (reg0_pull_low && reg1_pull_low)); // R6

    AST_CH1_KEEPS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg1_pull_low && reg1_en && !uvlo && !reg1_below) |=> !reg1_pull_low); // R9

endmodule

// File: tb/pg_reset_pair_test.sv
module pg_reset_pair_test;
    localparam int ENT0 = 100;
    localparam int EX0  = 25;
    localparam int ESTP = 50;
    localparam int XSTP = 5;
    localparam int MINS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uvlo = 1'b0;
    logic en0 = 1'b0, ab0 = 1'b0, be0 = 1'b0;
    logic en1 = 1'b0, ab1 = 1'b0, be1 = 1'b0;
    logic [7:0] dset = 8'd5;
    logic p0, p1;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pg_reset_pair #(
        .CLK_KHZ(1000), .CH0_ENTRY_US(100), .CH0_EXIT_US(25),
        .CH1_ENTRY_NOM_US(250), .CH1_EXIT_NOM_US(25), .CH1_NOM_SET(5),
        .MIN_EXIT_US(10), .SET_W(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .uvlo(uvlo),
        .reg0_en(en0), .reg0_above(ab0), .reg0_below(be0),
        .reg1_en(en1), .reg1_above(ab1), .reg1_below(be1),
        .reg1_delay_set(dset),
        .reg0_pull_low(p0), .reg1_pull_low(p1)
    );

    // behavioural reference: streak counters per rail
    bit mgood [2];
    bit marm  [2];
    int streak [2];
    int len1e, len1x;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                mgood[c] = 0; marm[c] = 0; streak[c] = 0;
            end
            len1e = MINS * ESTP;
            len1x = MINS * XSTP;
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit on, up, dn;
                int need_in, need_out;
                on = (c == 0 ? en0 : en1) && !uvlo;
                up = (c == 0) ? ab0 : ab1;
                dn = (c == 0) ? be0 : be1;
                need_in  = (c == 0) ? ENT0 : len1e;
                need_out = (c == 0) ? EX0 : len1x;
                if (!on) begin
                    mgood[c] = 0; marm[c] = 0; streak[c] = 0;
                end else if (!marm[c]) begin
                    marm[c] = 1; streak[c] = 0;
                end else if (!mgood[c]) begin
                    streak[c] = up ? streak[c] + 1 : 0;
                    if (streak[c] >= need_in) begin mgood[c] = 1; streak[c] = 0; end
                end else begin
                    streak[c] = dn ? streak[c] + 1 : 0;
                    if (streak[c] >= need_out) begin mgood[c] = 0; streak[c] = 0; end
                end
            end
            begin
                int s;
                s = (dset < MINS) ? MINS : int'(dset);
                len1e = s * ESTP;
                len1x = s * XSTP;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 R4 R6 R7 model rail0", int'(p0), int'(!mgood[0]));
            chk("R7 R8 R9 model rail1", int'(p1), int'(!mgood[1]));
        end
    end

    task automatic wait_pull(input int ch, input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (((ch == 0) ? p0 : p1) !== lvl && n < 2000);
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        chk("R1 reset rail0", int'(p0), 1);
        chk("R1 reset rail1", int'(p1), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset rail0", int'(p0), 1);

        // R2, R10: fresh start on rail 0
        en0 = 1; ab0 = 1;
        wait_pull(0, 1'b0, n);
        chk("R2 R10 entry rail0 edges", n, ENT0 + 1);

        // R5: band hold while good
        ab0 = 0;
        repeat (200) @(negedge clk);
        chk("R5 band keeps good", int'(p0), 0);

        // R4: exit with one break
        be0 = 1;
        repeat (24) @(negedge clk);
        chk("R4 not yet dropped", int'(p0), 0);
        be0 = 0;
        @(negedge clk);
        be0 = 1;
        wait_pull(0, 1'b1, n);
        chk("R4 exit edges after restart", n, EX0);

        // R5 not-good hold, R3 entry restart
        be0 = 0;
        repeat (50) @(negedge clk);
        chk("R5 band keeps low", int'(p0), 1);
        ab0 = 1;
        repeat (60) @(negedge clk);
        ab0 = 0;
        @(negedge clk);
        ab0 = 1;
        wait_pull(0, 1'b0, n);
        chk("R3 entry restart edges", n, ENT0);

        // R6: disable and lockout
        en0 = 0;
        @(negedge clk);
        chk("R6 disable pulls", int'(p0), 1);
        en0 = 1;
        wait_pull(0, 1'b0, n);
        chk("R6 re-entry full time", n, ENT0 + 1);
        repeat (90) @(negedge clk);
        uvlo = 1;
        @(negedge clk);
        chk("R6 lockout pulls", int'(p0), 1);
        uvlo = 0;
        wait_pull(0, 1'b0, n);
        chk("R6 after lockout", n, ENT0 + 1);

        // R7: scaled rail 1
        dset = 8'd5;
        repeat (2) @(negedge clk);
        en1 = 1; ab1 = 1;
        wait_pull(1, 1'b0, n);
        chk("R7 entry set5", n, 5 * ESTP + 1);
        ab1 = 0; be1 = 1;
        wait_pull(1, 1'b1, n);
        chk("R7 exit set5", n, 5 * XSTP);
        be1 = 0; en1 = 0; dset = 8'd3;
        repeat (2) @(negedge clk);
        en1 = 1; ab1 = 1;
        wait_pull(1, 1'b0, n);
        chk("R7 entry set3", n, 3 * ESTP + 1);
        ab1 = 0; be1 = 1;
        wait_pull(1, 1'b1, n);
        chk("R7 exit set3", n, 3 * XSTP);

        // R8: clamp
        be1 = 0; en1 = 0; dset = 8'd0;
        repeat (2) @(negedge clk);
        en1 = 1; ab1 = 1;
        wait_pull(1, 1'b0, n);
        chk("R8 entry set0", n, MINS * ESTP + 1);
        ab1 = 0; be1 = 1;
        wait_pull(1, 1'b1, n);
        chk("R8 exit set0", n, 10);
        be1 = 0; en1 = 0; dset = 8'd1;
        repeat (2) @(negedge clk);
        en1 = 1; ab1 = 1;
        wait_pull(1, 1'b0, n);
        chk("R8 entry set1", n, MINS * ESTP + 1);

        // R9: rail 0 disturbed, rail 1 unaffected
        en0 = 0;
        repeat (20) @(negedge clk);
        chk("R9 rail1 stays good", int'(p1), 0);
        chk("R9 rail0 pulled", int'(p0), 1);
        be0 = 1; en0 = 1;
        repeat (5) @(negedge clk);
        chk("R9 rail1 still good", int'(p1), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule